// File: doc/BRIEF.md
# Right-Justified Serial Audio Receiver

This block takes a three-wire serial PCM stream (bit clock, word clock and serial data) and recovers one signed 16-bit sample per channel per frame. The word clock splits each frame into two halves, one per channel. Within a half, only the final 16 bits before the word clock toggles carry the sample. Any bits ahead of them are padding and are thrown away. For this reason the same logic handles 48 and 64 bit clocks per frame, and no mode setting is needed.

All three serial lines are asynchronous to the system clock. Each goes through a synchronizer, and the bit clock is then edge-detected in the system clock domain. Once both halves of a frame are in, the block applies the word-clock polarity selection and the stereo or mono routing. It then presents the left and right words on registered outputs together with a single-cycle valid strobe. The outputs hold their value until the next frame completes.

Top module: `rj_audio_rx`

## Requirements
- R1: After reset, left_o and right_o are zero and valid_o is low. They stay that way until a frame with both halves complete has been received.
- R2: Data is sampled on the rising bit-clock edge, MSB first, in two's complement. A half carries the 16 bits that immediately precede the word-clock change. At 48 bit clocks per frame (24 per half), the first 8 bits of each half have no effect.
- R3: At 64 bit clocks per frame (32 per half), samples are recovered with no configuration change, and the first 16 bits of each half have no effect.
- R4: A half that spans fewer than 16 rising bit-clock edges is discarded and never published.
- R5: With lr_pol_i low, the half where the word clock is low is the right channel and the high half is the left. With lr_pol_i high, the low half is the left channel and the high half is the right.
- R6: With mono_i low, left_o carries the left sample and right_o carries the right sample.
- R7: With mono_i high and chsel_i high, both outputs carry the left sample. The routing inputs are sampled only when a frame is published, so changing them between frames leaves the outputs unchanged.
- R8: With mono_i high and chsel_i low, both outputs carry the right sample.
- R9: valid_o is high for exactly one system clock per completed frame, and the outputs change only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bck_i | input | 1 | Serial bit clock (asynchronous) |
| wclk_i | input | 1 | Word clock that selects the channel half (asynchronous) |
| sdata_i | input | 1 | Serial sample data, MSB first |
| lr_pol_i | input | 1 | Word-clock polarity: 0 = low half is right, 1 = low half is left |
| mono_i | input | 1 | 1 selects mono routing |
| chsel_i | input | 1 | In mono routing, 1 copies left and 0 copies right |
| left_o | output | SAMPLE_W | Left output sample |
| right_o | output | SAMPLE_W | Right output sample |
| valid_o | output | 1 | One-cycle strobe for each published frame |

## Verification
The bench builds the block with SAMPLE_W = 16 and SYNC_STAGES = 2, and holds each bit-clock phase for 8 system clocks. These settings put both frame lengths of 48 and 64 bit clocks within reach, along with short halves below the 16-bit threshold and padding bits that differ from the sample. Every frame places distinct values in the two halves, so a mistake in polarity, routing or bit alignment shows up as a wrong word at the output. The bench also counts valid strobes and checks their width, which confirms that discarded halves and mid-stream routing changes produce no publication.

// File: rtl/rj_audio_pkg.sv
package rj_audio_pkg;

  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } chan_e;

  // Map the word-clock level of a closed half to its channel.
  function automatic chan_e half_chan(input logic lvl, input logic pol);
    return (lvl ^ pol) ? CH_LEFT : CH_RIGHT;
  endfunction

endpackage

// File: rtl/rj_audio_sync.sv
module rj_audio_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= '0;
      else     stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/rj_audio_deser.sv
module rj_audio_deser #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bck_s,
  input  logic                wclk_s,
  input  logic                sd_s,
  output logic                cap_stb,
  output logic                cap_lvl,
  output logic [SAMPLE_W-1:0] cap_word
);

  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SAMPLE_W);

  logic                bck_q;
  logic                wclk_last;
  logic [SAMPLE_W-1:0] shreg;
  logic [CNT_W-1:0]    nbits;
  logic                bck_rise;
  logic                wclk_turn;

  assign bck_rise  = bck_s & ~bck_q;
  assign wclk_turn = bck_rise && (wclk_s != wclk_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      bck_q     <= 1'b0;
      wclk_last <= 1'b0;
      shreg     <= '0;
      nbits     <= '0;
      cap_stb   <= 1'b0;
      cap_lvl   <= 1'b0;
      cap_word  <= '0;
    end else begin
      bck_q   <= bck_s;
      cap_stb <= 1'b0;
      if (bck_rise) begin
        shreg     <= {shreg[SAMPLE_W-2:0], sd_s};
        wclk_last <= wclk_s;
        if (wclk_turn) begin
          nbits <= CNT_W'(1);
          if (nbits == CNT_FULL) begin
            cap_stb  <= 1'b1;
            cap_lvl  <= wclk_last;
            cap_word <= shreg;
          end
        end else if (nbits != CNT_FULL) begin
          nbits <= nbits + CNT_W'(1);
        end
      end
    end
  end

  // R4
  nbits_range_chk: assert property (@(posedge clk) disable iff (rst)
    nbits <= CNT_FULL);

  // R2
  cap_level_chk: assert property (@(posedge clk) disable iff (rst)
    cap_stb |-> (cap_lvl != wclk_last));

endmodule

// File: rtl/rj_audio_route.sv
module rj_audio_route #(
  parameter int SAMPLE_W = 16
) (
  input  logic [SAMPLE_W-1:0] in_l,
  input  logic [SAMPLE_W-1:0] in_r,
  input  logic                mono,
  input  logic                chsel,
  output logic [SAMPLE_W-1:0] out_l,
  output logic [SAMPLE_W-1:0] out_r
);

  always_comb begin
    if (!mono) begin
      out_l = in_l;
      out_r = in_r;
    end else if (chsel) begin
      out_l = in_l;
      out_r = in_l;
    end else begin
      out_l = in_r;
      out_r = in_r;
    end
  end

endmodule

// File: rtl/rj_audio_frame.sv
module rj_audio_frame
  import rj_audio_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_stb,
  input  logic                cap_lvl,
  input  logic [SAMPLE_W-1:0] cap_word,
  input  logic                lr_pol,
  input  logic                mono,
  input  logic                chsel,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);

  logic [SAMPLE_W-1:0] hold_l, hold_r;
  logic                have_l, have_r;
  chan_e               ch;
  logic                complete;
  logic [SAMPLE_W-1:0] frame_l, frame_r;
  logic [SAMPLE_W-1:0] rout_l, rout_r;

  assign ch       = half_chan(cap_lvl, lr_pol);
  assign complete = cap_stb && ((ch == CH_LEFT) ? have_r : have_l);
  assign frame_l  = (ch == CH_LEFT)  ? cap_word : hold_l;
  assign frame_r  = (ch == CH_RIGHT) ? cap_word : hold_r;

  rj_audio_route #(.SAMPLE_W(SAMPLE_W)) u_route (
    .in_l  (frame_l),
    .in_r  (frame_r),
    .mono  (mono),
    .chsel (chsel),
    .out_l (rout_l),
    .out_r (rout_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_l  <= '0;
      hold_r  <= '0;
      have_l  <= 1'b0;
      have_r  <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (complete) begin
        left_o  <= rout_l;
        right_o <= rout_r;
        valid_o <= 1'b1;
        have_l  <= 1'b0;
        have_r  <= 1'b0;
      end else if (cap_stb) begin
        if (ch == CH_LEFT) begin
          hold_l <= cap_word;
          have_l <= 1'b1;
        end else begin
          hold_r <= cap_word;
          have_r <= 1'b1;
        end
      end
    end
  end

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R9
  pending_pair_chk: assert property (@(posedge clk) disable iff (rst)
    !(have_l && have_r));

  // R7
  mono_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(mono)) |-> (left_o == right_o));

endmodule

// File: rtl/rj_audio_rx.sv
module rj_audio_rx #(
  parameter int SAMPLE_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bck_i,
  input  logic                wclk_i,
  input  logic                sdata_i,
  input  logic                lr_pol_i,
  input  logic                mono_i,
  input  logic                chsel_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);

  localparam int NLINES = 3;

  logic [NLINES-1:0]   lines_s;
  logic                cap_stb;
  logic                cap_lvl;
  logic [SAMPLE_W-1:0] cap_word;

  rj_audio_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({bck_i, wclk_i, sdata_i}),
    .q_o (lines_s)
  );

  rj_audio_deser #(.SAMPLE_W(SAMPLE_W)) u_deser (
    .clk      (clk),
    .rst      (rst),
    .bck_s    (lines_s[2]),
    .wclk_s   (lines_s[1]),
    .sd_s     (lines_s[0]),
    .cap_stb  (cap_stb),
    .cap_lvl  (cap_lvl),
    .cap_word (cap_word)
  );

  rj_audio_frame #(.SAMPLE_W(SAMPLE_W)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .cap_stb  (cap_stb),
    .cap_lvl  (cap_lvl),
    .cap_word (cap_word),
    .lr_pol   (lr_pol_i),
    .mono     (mono_i),
    .chsel    (chsel_i),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    $past(rst) |-> (left_o == '0 && right_o == '0 && !valid_o));

endmodule

// File: tb/tb_rj_audio_rx.sv
module tb_rj_audio_rx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bck = 1'b0, wclk = 1'b0, sd = 1'b0;
  logic        pol = 1'b0, mono = 1'b0, chsel = 1'b0;
  logic [15:0] left_o, right_o;
  logic        valid_o;

  int checks = 0, fails = 0, pulses = 0, width_err = 0, base = 0;
  bit vprev = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  rj_audio_rx #(.SAMPLE_W(16), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .bck_i(bck), .wclk_i(wclk), .sdata_i(sd),
    .lr_pol_i(pol), .mono_i(mono), .chsel_i(chsel),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always @(negedge clk) begin
    if (!rst && valid_o) begin
      pulses++;
      if (vprev) width_err++;
    end
    vprev = valid_o;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; bck = 0; wclk = 0; sd = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    base = pulses;
  endtask

  task automatic send_bit(logic lvl, logic b);
    @(negedge clk);
    bck = 1'b0; wclk = lvl; sd = b;
    repeat (8) @(negedge clk);
    bck = 1'b1;
    repeat (7) @(negedge clk);
  endtask

  task automatic send_half(logic lvl, logic [15:0] w, int n, logic [15:0] junk);
    for (int i = 0; i < n; i++) begin
      int idx = n - 1 - i;
      send_bit(lvl, (idx < 16) ? w[idx] : junk[idx % 16]);
    end
  endtask

  task automatic send_frame(logic [15:0] hi, logic [15:0] lo, int n);
    send_half(1'b1, hi, n, 16'hC3A5);
    send_half(1'b0, lo, n, 16'h5A3C);
  endtask

  task automatic close_frame();
    send_bit(1'b1, 1'b1);
    send_bit(1'b1, 1'b0);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 left after reset", left_o, 0);
    chk("R1 right after reset", right_o, 0);
    chk("R1 valid after reset", valid_o, 0);
    send_half(1'b1, 16'hBEEF, 24, 16'h1234);
    close_frame();
    chk("R1 no pulse on lone half", pulses - base, 0);
    chk("R1 left stays zero", left_o, 0);
  endtask

  task automatic t_stereo48();
    do_reset(); pol = 0; mono = 0;
    send_frame(16'h1234, 16'hA5F0, 24);
    close_frame();
    chk("R2 left 48fs", left_o, 16'h1234);
    chk("R6 right 48fs", right_o, 16'hA5F0);
    chk("R9 one pulse", pulses - base, 1);
  endtask

  task automatic t_stereo64();
    do_reset(); pol = 0; mono = 0;
    send_frame(16'h0F0F, 16'hFFFE, 32);
    close_frame();
    chk("R3 left 64fs", left_o, 16'h0F0F);
    chk("R3 right 64fs", right_o, 16'hFFFE);
    send_frame(16'h8001, 16'h7FFE, 32);
    close_frame();
    chk("R3 left second frame", left_o, 16'h8001);
    chk("R3 right second frame", right_o, 16'h7FFE);
    chk("R9 two pulses", pulses - base, 2);
    repeat (50) @(negedge clk);
    chk("R9 left held idle", left_o, 16'h8001);
  endtask

  task automatic t_polarity();
    do_reset(); pol = 1; mono = 0;
    send_frame(16'h7FFF, 16'h8000, 24);
    close_frame();
    chk("R5 left from low half", left_o, 16'h8000);
    chk("R5 right from high half", right_o, 16'h7FFF);
    pol = 0;
  endtask

  task automatic t_mono();
    do_reset(); pol = 0; mono = 0;
    send_frame(16'h4444, 16'h5555, 24);
    close_frame();
    mono = 1; chsel = 1;
    repeat (40) @(negedge clk);
    chk("R7 routing change alone no effect", right_o, 16'h5555);
    send_frame(16'h1111, 16'h2222, 24);
    close_frame();
    chk("R7 left copy on left", left_o, 16'h1111);
    chk("R7 left copy on right", right_o, 16'h1111);
    chsel = 0;
    send_frame(16'h3333, 16'h6666, 24);
    close_frame();
    chk("R8 right copy on left", left_o, 16'h6666);
    chk("R8 right copy on right", right_o, 16'h6666);
    mono = 0;
  endtask

  task automatic t_short();
    do_reset(); pol = 0; mono = 0;
    send_half(1'b1, 16'h0155, 10, 16'h0);
    send_half(1'b0, 16'h3333, 24, 16'hFFFF);
    close_frame();
    chk("R4 short half not published", pulses - base, 0);
    chk("R4 left still zero", left_o, 0);
    chk("R9 pulse width", width_err, 0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_stereo48();
    t_stereo64();
    t_polarity();
    t_mono();
    t_short();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual hung expected finished");
      report();
    end
  end

endmodule